// File: doc/BRIEF.md
# Bus Trigger Match Sequencer

This block turns activity on a monitored signal vector into a one-clock trigger pulse for an on-chip bus monitor. It holds one or two match units. Each unit tests the vector every clock, either bit by bit against a set of per-bit conditions or, when the build allows it, as an unsigned number against programmed bounds. Per-bit conditions can be levels, don't-care, or edges. Edges are found by comparing the vector with a copy of it registered one clock earlier.

Software or a debug controller loads the compare settings and pulses an arm input. The sequencer then waits for unit A. In a two-unit build it next waits for unit B on a strictly later clock. Each completed pass is one occurrence. When the occurrence count reaches the programmed target, the trigger output pulses for one clock and the sequencer goes back to idle until it is armed again. Build parameters set the vector width, the number of units, whether the numeric compare modes exist, the occurrence counter width, and whether the group is present at all.

Top module: `trig_match_seq`

## Requirements
- R1: While the reset is asserted and after it is released, `trig_o` is 0, the sequencer is idle with its occurrence count at zero, and the stored previous sample of the vector is all zeros.
- R2: In bitwise mode each bit `i` uses the 3-bit code at `code[3*i+2:3*i]`: 0 means the bit is low, 1 means the bit is high, 2 means don't-care, 3 means rising, 4 means falling, 5 means any edge. Codes 6 and 7 act as don't-care. A unit hits only when every bit meets its condition.
- R3: The edge codes compare the bit's current value with its value at the previous clock edge. Rising is previous 0 and now 1. Falling is previous 1 and now 0. Any edge is the two values differing.
- R4: When `FULL_CMP` is 1, a nonzero mode selects a numeric unsigned compare of the vector `v` against `lo` and `hi`: 1 is v==lo, 2 is v!=lo, 3 is v>lo, 4 is v<lo, 5 is v>=lo, 6 is v<=lo, 7 is lo<=v<=hi, 8 is v<lo or v>hi. Modes 9 to 15 never hit. Mode 0 selects bitwise compare.
- R5: When `FULL_CMP` is 0, the mode, `lo` and `hi` inputs are ignored and every unit uses the bitwise compare.
- R6: The sequencer leaves idle only on the clock edge where `arm_i` is high. `arm_i` has no effect while the sequencer is not idle.
- R7: With `NUM_UNITS`=2, an occurrence is a hit of unit A followed by a hit of unit B on a strictly later clock. A unit B hit in the same cycle as the unit A hit, or before it, does not count.
- R8: With `CNT_W`>0, the trigger fires on the occurrence whose number equals `target_i`, where a target of 0 counts as 1. After an occurrence that is not the final one, the sequencer waits for unit A again.
- R9: With `CNT_W`=0, the trigger fires on the first occurrence and `target_i` is ignored.
- R10: `trig_o` goes high for exactly one clock, starting at the clock edge that follows the edge where the final occurrence was seen. The sequencer is idle at that point.
- R11: With `ENABLE`=0, `trig_o` never goes high, whatever the inputs.
- R12: With `NUM_UNITS`=1, each hit of unit A is an occurrence, and the unit B inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm_i | input | 1 | Starts a search when the sequencer is idle |
| mon_i | input | W | Monitored signal vector |
| code_a_i | input | 3*W | Unit A per-bit condition codes |
| mode_a_i | input | 4 | Unit A compare mode |
| lo_a_i | input | W | Unit A compare value or lower bound |
| hi_a_i | input | W | Unit A upper bound |
| code_b_i | input | 3*W | Unit B per-bit condition codes |
| mode_b_i | input | 4 | Unit B compare mode |
| lo_b_i | input | W | Unit B compare value or lower bound |
| hi_b_i | input | W | Unit B upper bound |
| target_i | input | max(CNT_W,1) | Occurrence count that fires the trigger |
| trig_o | output | 1 | One-clock trigger pulse |

## Verification
The assertions assume that every input is synchronous to `clk` and settles between edges. They also assume that `rst_n` is low from time zero until a few clocks have passed, so the sequencer state is known before any property samples it. The bench changes all stimulus on the falling edge only. It holds the monitored vector at zero from the start of reset until the internal reset has been released. This makes the edge history seen by the design agree with the zeros the bench's own model starts from.

// File: rtl/trig_pkg.sv
package trig_pkg;

  // Per-bit condition codes; 6 and 7 behave as don't-care.
  localparam logic [2:0] BC_LOW  = 3'd0;
  localparam logic [2:0] BC_HIGH = 3'd1;
  localparam logic [2:0] BC_ANY  = 3'd2;
  localparam logic [2:0] BC_RISE = 3'd3;
  localparam logic [2:0] BC_FALL = 3'd4;
  localparam logic [2:0] BC_EDGE = 3'd5;

  // Unit compare modes; nonzero modes exist only in full-compare builds.
  localparam logic [3:0] CM_BITS = 4'd0;
  localparam logic [3:0] CM_EQ   = 4'd1;
  localparam logic [3:0] CM_NE   = 4'd2;
  localparam logic [3:0] CM_GT   = 4'd3;
  localparam logic [3:0] CM_LT   = 4'd4;
  localparam logic [3:0] CM_GE   = 4'd5;
  localparam logic [3:0] CM_LE   = 4'd6;
  localparam logic [3:0] CM_IN   = 4'd7;
  localparam logic [3:0] CM_OUT  = 4'd8;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_WAIT_A = 2'd1,
    SQ_WAIT_B = 2'd2
  } seq_state_e;

endpackage

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import trig_pkg::*;
#(
  parameter int W        = 8,
  parameter int FULL_CMP = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    mon_i,
  input  logic [3*W-1:0]  code_i,
  input  logic [3:0]      mode_i,
  input  logic [W-1:0]    lo_i,
  input  logic [W-1:0]    hi_i,
  output logic            hit_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] bit_ok;
  logic         num_hit;

  // Edge history: one-clock delayed copy of the vector.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= mon_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [2:0] c;
    logic       cur;
    logic       old;
    assign c   = code_i[3*i +: 3];
    assign cur = mon_i[i];
    assign old = prev_q[i];
    assign bit_ok[i] = (c == BC_LOW)  ? ~cur :
                       (c == BC_HIGH) ?  cur :
                       (c == BC_RISE) ? (~old &  cur) :
                       (c == BC_FALL) ? ( old & ~cur) :
                       (c == BC_EDGE) ? ( old ^  cur) : 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      CM_EQ:   num_hit = (mon_i == lo_i);
      CM_NE:   num_hit = (mon_i != lo_i);
      CM_GT:   num_hit = (mon_i >  lo_i);
      CM_LT:   num_hit = (mon_i <  lo_i);
      CM_GE:   num_hit = (mon_i >= lo_i);
      CM_LE:   num_hit = (mon_i <= lo_i);
      CM_IN:   num_hit = (mon_i >= lo_i) && (mon_i <= hi_i);
      CM_OUT:  num_hit = (mon_i <  lo_i) || (mon_i >  hi_i);
      default: num_hit = 1'b0;
    endcase
  end

  // Basic-only builds ignore the mode; the numeric path is then pruned.
  assign hit_o = ((FULL_CMP != 0) && (mode_i != CM_BITS)) ? num_hit : (&bit_ok);

endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  parameter int CNT_W     = 3,
  parameter int ENABLE    = 1,
  localparam int TW       = (CNT_W > 0) ? CNT_W : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          hit_a_i,
  input  logic          hit_b_i,
  input  logic [TW-1:0] target_i,
  output logic          trig_o,
  output seq_state_e    state_o
);

  localparam logic [TW:0] ONE_X = (TW+1)'(1);

  seq_state_e  st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic        cnt_en;
  logic        trig_q;
  logic        evt;
  logic        fire;
  logic        reached;
  logic [TW-1:0] tgt_eff;

  assign tgt_eff = (target_i == '0) ? TW'(1) : target_i;
  assign reached = (CNT_W == 0) || (({1'b0, cnt_q} + ONE_X) >= {1'b0, tgt_eff});

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    evt    = 1'b0;
    fire   = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (arm_i && (ENABLE != 0)) st_d = SQ_WAIT_A;
      end
      SQ_WAIT_A: begin
        if (hit_a_i) begin
          if (NUM_UNITS > 1) st_d = SQ_WAIT_B;
          else               evt  = 1'b1;
        end
      end
      SQ_WAIT_B: begin
        if (hit_b_i) evt = 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase
    if (evt) begin
      cnt_en = 1'b1;
      if (reached) begin
        fire  = 1'b1;
        cnt_d = '0;
        st_d  = SQ_IDLE;
      end else begin
        cnt_d = cnt_q + TW'(1);
        st_d  = SQ_WAIT_A;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      trig_q <= fire;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign trig_o  = trig_q;
  assign state_o = st_q;

endmodule

// File: rtl/trig_match_seq.sv
module trig_match_seq
  import trig_pkg::*;
#(
  parameter int W         = 8,
  parameter int NUM_UNITS = 2,
  parameter int FULL_CMP  = 1,
  parameter int CNT_W     = 3,
  parameter int ENABLE    = 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               arm_i,
  input  logic [W-1:0]                       mon_i,
  input  logic [3*W-1:0]                     code_a_i,
  input  logic [3:0]                         mode_a_i,
  input  logic [W-1:0]                       lo_a_i,
  input  logic [W-1:0]                       hi_a_i,
  input  logic [3*W-1:0]                     code_b_i,
  input  logic [3:0]                         mode_b_i,
  input  logic [W-1:0]                       lo_b_i,
  input  logic [W-1:0]                       hi_b_i,
  input  logic [((CNT_W > 0) ? CNT_W : 1)-1:0] target_i,
  output logic                               trig_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       hit_a;
  logic       hit_b;
  seq_state_e seq_state;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  trig_match_unit #(.W(W), .FULL_CMP(FULL_CMP)) u_unit_a (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .mon_i  (mon_i),
    .code_i (code_a_i),
    .mode_i (mode_a_i),
    .lo_i   (lo_a_i),
    .hi_i   (hi_a_i),
    .hit_o  (hit_a)
  );

  trig_match_unit #(.W(W), .FULL_CMP(FULL_CMP)) u_unit_b (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .mon_i  (mon_i),
    .code_i (code_b_i),
    .mode_i (mode_b_i),
    .lo_i   (lo_b_i),
    .hi_i   (hi_b_i),
    .hit_o  (hit_b)
  );

  trig_seq_ctrl #(.NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W), .ENABLE(ENABLE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .arm_i    (arm_i),
    .hit_a_i  (hit_a),
    .hit_b_i  (hit_b),
    .target_i (target_i),
    .trig_o   (trig_o),
    .state_o  (seq_state)
  );

endmodule

// File: rtl/trig_match_seq_chk.sv
module trig_match_seq_chk
  import trig_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  parameter int ENABLE    = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       arm_i,
  input logic       trig_o,
  input logic       hit_a,
  input logic       hit_b,
  input seq_state_e seq_state
);

  localparam seq_state_e LAST_ST = (NUM_UNITS > 1) ? SQ_WAIT_B : SQ_WAIT_A;

  // R10: a pulse lasts one clock
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // R10: idle once the pulse is out
  p_idle_on_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (seq_state == SQ_IDLE));

  // R6: no arm, no departure from idle
  p_stay_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SQ_IDLE && !arm_i) |=> (seq_state == SQ_IDLE));

  // R7: a trigger follows the last step of the ordering
  p_last_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> ($past(seq_state) == LAST_ST));

  // R7: the final unit hit caused it
  p_last_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> ((NUM_UNITS > 1) ? $past(hit_b) : $past(hit_a)));

  // R11: disabled group stays silent
  p_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ENABLE == 0) |-> !trig_o);

endmodule

bind trig_match_seq trig_match_seq_chk #(.NUM_UNITS(NUM_UNITS), .ENABLE(ENABLE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm_i     (arm_i),
  .trig_o    (trig_o),
  .hit_a     (hit_a),
  .hit_b     (hit_b),
  .seq_state (seq_state)
);

// File: tb/trig_match_seq_tb.sv
module trig_match_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        arm;
  logic [7:0]  mon;
  logic [23:0] code_a, code_b;
  logic [3:0]  mode_a, mode_b;
  logic [7:0]  lo_a, hi_a, lo_b, hi_b;
  logic [2:0]  tgt;
  logic        trig_main, trig_one, trig_off;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  bit in_reset;

  // model configuration: main, single-unit basic, disabled
  int cfg_units[3] = '{2, 1, 2};
  int cfg_full[3]  = '{1, 0, 1};
  int cfg_cntw[3]  = '{3, 0, 3};
  int cfg_en[3]    = '{1, 1, 0};
  int ms_st[3];
  int ms_cnt[3];
  logic [7:0] ms_prev[3];
  bit exp_trig[3];
  int fires_main = 0;
  int fires_one  = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  trig_match_seq u_dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .mon_i(mon),
    .code_a_i(code_a), .mode_a_i(mode_a), .lo_a_i(lo_a), .hi_a_i(hi_a),
    .code_b_i(code_b), .mode_b_i(mode_b), .lo_b_i(lo_b), .hi_b_i(hi_b),
    .target_i(tgt), .trig_o(trig_main));

  trig_match_seq #(.NUM_UNITS(1), .FULL_CMP(0), .CNT_W(0)) u_dut_single (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .mon_i(mon),
    .code_a_i(code_a), .mode_a_i(mode_a), .lo_a_i(lo_a), .hi_a_i(hi_a),
    .code_b_i(code_b), .mode_b_i(mode_b), .lo_b_i(lo_b), .hi_b_i(hi_b),
    .target_i(tgt[0]), .trig_o(trig_one));

  trig_match_seq #(.ENABLE(0)) u_dut_off (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .mon_i(mon),
    .code_a_i(code_a), .mode_a_i(mode_a), .lo_a_i(lo_a), .hi_a_i(hi_a),
    .code_b_i(code_b), .mode_b_i(mode_b), .lo_b_i(lo_b), .hi_b_i(hi_b),
    .target_i(tgt), .trig_o(trig_off));

  function automatic bit ref_hit(int full, logic [7:0] cur, logic [7:0] prv,
                                 logic [23:0] code, logic [3:0] mode,
                                 logic [7:0] lo, logic [7:0] hi);
    bit ok = 1'b1;
    if (full != 0 && mode != 4'd0) begin
      case (mode)
        4'd1: return cur == lo;
        4'd2: return cur != lo;
        4'd3: return cur > lo;
        4'd4: return cur < lo;
        4'd5: return cur >= lo;
        4'd6: return cur <= lo;
        4'd7: return (cur >= lo) && (cur <= hi);
        4'd8: return (cur < lo) || (cur > hi);
        default: return 1'b0;
      endcase
    end
    for (int i = 0; i < 8; i++) begin
      case (code[3*i +: 3])
        3'd0: ok &= !cur[i];
        3'd1: ok &= cur[i];
        3'd3: ok &= !prv[i] && cur[i];
        3'd4: ok &= prv[i] && !cur[i];
        3'd5: ok &= prv[i] != cur[i];
        default: ;
      endcase
    end
    return ok;
  endfunction

  task automatic model_step(input int k);
    bit ha, hb, evt, fire;
    int ns, goal;
    if (in_reset) begin
      ms_st[k] = 0; ms_cnt[k] = 0; ms_prev[k] = 8'h00; exp_trig[k] = 1'b0;
      return;
    end
    ha = ref_hit(cfg_full[k], mon, ms_prev[k], code_a, mode_a, lo_a, hi_a);
    hb = ref_hit(cfg_full[k], mon, ms_prev[k], code_b, mode_b, lo_b, hi_b);
    evt = 0; fire = 0; ns = ms_st[k];
    if (cfg_en[k] != 0) begin
      case (ms_st[k])
        0: if (arm) ns = 1;
        1: if (ha) begin
             if (cfg_units[k] > 1) ns = 2; else evt = 1;
           end
        default: if (hb) evt = 1;
      endcase
    end
    if (evt) begin
      goal = (cfg_cntw[k] == 0) ? 1 : ((tgt == 0) ? 1 : int'(tgt));
      if (ms_cnt[k] + 1 >= goal) begin
        fire = 1; ms_cnt[k] = 0; ns = 0;
      end else begin
        ms_cnt[k]++; ns = 1;
      end
    end
    ms_st[k] = ns;
    ms_prev[k] = mon;
    exp_trig[k] = fire;
  endtask

  task automatic chk(input string tag, input logic act, input bit expv);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s: trig actual=%b expected=%b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic tick(input string tag_main, input string tag_one);
    for (int k = 0; k < 3; k++) model_step(k);
    @(posedge clk);
    @(negedge clk);
    chk(tag_main, trig_main, exp_trig[0]);
    chk(tag_one, trig_one, exp_trig[1]);
    chk("R11", trig_off, exp_trig[2]);
    if (exp_trig[0]) fires_main++;
    if (exp_trig[1]) fires_one++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_reset = 1'b1; arm = 1'b0; mon = 8'h00;
    for (int i = 0; i < 3; i++) tick("R1", "R1");
    rst_n = 1'b1; in_reset = 1'b0;
    for (int i = 0; i < 4; i++) tick("R1", "R1");
  endtask

  function automatic logic [23:0] all_any();
    return {8{3'd2}};
  endfunction

  initial begin : watchdog
    #1500000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    int fm_before;
    void'($urandom(32'd20240611));
    code_a = all_any(); code_b = all_any();
    mode_a = 4'd0; mode_b = 4'd0;
    lo_a = 8'h00; hi_a = 8'h00; lo_b = 8'h00; hi_b = 8'h00;
    tgt = 3'd1;
    do_reset();

    // R7 / R3: bit0 high, then a later rising edge on bit1
    code_a[2:0] = 3'd1;
    code_b[5:3] = 3'd3;
    arm = 1'b1; tick("R6", "R6");
    arm = 1'b0;
    fm_before = fires_main;
    mon = 8'b011; tick("R7", "R12");   // same-cycle rise must not count
    mon = 8'b011; tick("R7", "R12");
    mon = 8'b001; tick("R3", "R12");
    mon = 8'b011; tick("R7", "R12");   // fires next
    tick("R10", "R10");
    tick("R10", "R10");
    n_checks++;
    if (fires_main - fm_before != 1) begin
      n_errors++;
      $display("FAIL R7: sequence pulses actual=%0d expected=1", fires_main - fm_before);
    end

    // R8: three completed sequences; target 3 then target 0
    tgt = 3'd3;
    arm = 1'b1; tick("R8", "R9");
    arm = 1'b0;
    for (int i = 0; i < 14; i++) begin
      mon = (i % 2 == 0) ? 8'b001 : 8'b011;
      tick("R8", "R9");
    end
    tgt = 3'd0;
    arm = 1'b1; tick("R8", "R9");
    arm = 1'b0;
    for (int i = 0; i < 6; i++) begin
      mon = (i % 2 == 0) ? 8'b001 : 8'b011;
      tick("R8", "R9");
    end

    // R4 / R5: range modes on main, bitwise on the basic-only build
    tgt = 3'd1;
    mode_a = 4'd7; lo_a = 8'd10; hi_a = 8'd20;
    mode_b = 4'd8; lo_b = 8'd10; hi_b = 8'd20;
    code_a = all_any(); code_a[23:21] = 3'd0;
    code_b = all_any(); code_b[20:18] = 3'd5;
    for (int v = 0; v < 40; v += 3) begin
      arm = 1'b1; mon = 8'(v); tick("R4", "R5");
      arm = 1'b0; mon = 8'(v + 9); tick("R4", "R5");
      mon = 8'(v + 70); tick("R4", "R5");
    end

    // R6: arm held high throughout
    mode_a = 4'd0; mode_b = 4'd0;
    code_a = all_any(); code_a[2:0] = 3'd4;
    code_b = all_any(); code_b[2:0] = 3'd3;
    arm = 1'b1;
    for (int i = 0; i < 20; i++) begin
      mon = (i % 3 == 0) ? 8'h01 : 8'h00;
      tick("R6", "R6");
    end
    arm = 1'b0;

    // R1: reset in the middle of a sequence
    code_a = all_any(); code_b = all_any(); code_b[2:0] = 3'd1;
    arm = 1'b1; tick("R1", "R1");
    arm = 1'b0; tick("R1", "R1");
    do_reset();
    mon = 8'h01; tick("R1", "R1");
    tick("R1", "R1");

    // R2: random traffic with reconfiguration
    fm_before = fires_main;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc % 64 == 0) begin
        for (int b = 0; b < 8; b++) begin
          code_a[3*b +: 3] = ($urandom % 10 < 6) ? 3'd2 : 3'($urandom % 8);
          code_b[3*b +: 3] = ($urandom % 10 < 6) ? 3'd2 : 3'($urandom % 8);
        end
        mode_a = 4'($urandom % 11);
        mode_b = 4'($urandom % 11);
        if (mode_a > 4'd9) mode_a = 4'd0;
        if (mode_b > 4'd9) mode_b = 4'd0;
        lo_a = 8'($urandom); hi_a = 8'($urandom);
        lo_b = 8'($urandom); hi_b = 8'($urandom);
        tgt = 3'($urandom % 8);
      end
      arm = ($urandom % 4 == 0);
      if ($urandom % 2 == 0) mon = mon ^ 8'(1 << ($urandom % 8));
      if ($urandom % 16 == 0) mon = 8'($urandom);
      tick("R2", "R12");
    end
    n_checks++;
    if (fires_main == fm_before || fires_one == 0) begin
      n_errors++;
      $display("FAIL R10: random pulses actual=%0d/%0d expected=nonzero",
               fires_main - fm_before, fires_one);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule